// File: doc/BRIEF.md
# Edge-Interrupt Field I/O Register Set

This block is a small bank of 16-bit registers that controls a group of general-purpose field pins. The pins are arranged in byte lanes of eight. Each lane has one direction bit. A shared data register drives the pins that are outputs, and a readback register reports the levels on the pins. Each pin also feeds an edge detector. The detector compares the synchronised level against its value on the previous clock and reports low-to-high and high-to-low changes separately.

For each edge type there is an enable mask and a sticky status register. A status register is cleared by writing ones to the bits to be cleared. The control word shows, for each lane, whether a rise is pending, whether a fall is pending, and whether either is pending. A single interrupt line is high whenever any status bit is set. Software configures the block through a plain synchronous register port, services the interrupt by reading the status registers, and acknowledges it by writing the same bits back.

Top module: `fio_edge_regs`

## Requirements
- R1: After reset, every register reads 0, and `pin_out`, `pin_oe` and `irq` are 0.
- R2: Offset 0 is the control word. On a write to offset 0, bit 0 sets the direction of pins 7..0 and bit 8 sets the direction of pins 15..8, where 1 means output and drives `pin_oe` high for the whole lane. The direction bits take effect on the clock after the write. Control bits 1-4 and 9-12 always read 0, whatever is written to them.
- R3: Offset 1 holds output data. A write appears on `pin_out` one clock later, and a read of offset 1 returns the stored value.
- R4: Offset 2 returns the pin levels after a two-flop synchronizer. A change on `pin_in` is first visible on the second rising clock edge after it is applied.
- R5: Offset 3 is the rise status and offset 4 is the rise enable. A pin that goes from 0 to 1 while its enable bit is set sets its status bit on the third rising clock edge after the input change, and not before.
- R6: Offset 5 is the fall status and offset 6 is the fall enable. A pin that goes from 1 to 0 while its enable bit is set sets its status bit with the same three-edge latency as R5.
- R7: A status bit stays set until it is cleared. An edge on a pin whose enable bit is 0 sets nothing. Setting an enable bit after an edge has occurred does not record that earlier edge.
- R8: A write to offset 3 or offset 5 clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R9: If an enabled edge arrives in the same cycle as a clearing write to that bit, the status bit stays set.
- R10: Control bits 6, 5 and 7 are the rise-pending, fall-pending and any-pending flags for pins 7..0. Bits 14, 13 and 15 are the same three flags for pins 15..8.
- R11: `irq` is high exactly when at least one rise or fall status bit is set.
- R12: Offset 7 reads 0, and writes to offset 7 have no effect. Writes to offset 2 do not change what offset 2 returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_in | input | 16 | Field pin levels, asynchronous |
| pin_out | output | 16 | Output data driven to the pins |
| pin_oe | output | 16 | Per-pin output enable, set by the lane direction bits |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The bench places a clearing write on the exact cycle in which a new enabled edge is being detected. A design in which the clear wins would lose that edge, and the status bit would read 0. It also writes zero masks and partial masks to the status registers. This exposes a design that clears the whole register, or one that treats the write as a plain overwrite.

Other tests turn an enable on after an edge has occurred, and drive edges on pins that are not enabled. Either case would leave a wrong status bit set if the enable were applied late or not applied at all. Status is sampled one edge before and one edge after the expected latency, so an extra or a missing synchronizer stage shows up. The lane summary bits are checked with both edge types pending in different lanes at the same time, which catches swapped rise and fall flags or swapped lanes.

// File: rtl/fio_pkg.sv
package fio_pkg;

    localparam int LANE_W = 8;

    // Bit positions within each control-word byte lane
    localparam int DIR_BIT  = 0;
    localparam int FALL_BIT = 5;
    localparam int RISE_BIT = 6;
    localparam int ANY_BIT  = 7;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_DOUT  = 3'd1,
        SEL_DIN   = 3'd2,
        SEL_RSTAT = 3'd3,
        SEL_REN   = 3'd4,
        SEL_FSTAT = 3'd5,
        SEL_FEN   = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic any;
        logic rise;
        logic fall;
    } lane_flags_t;

    function automatic logic [LANE_W-1:0] pack_ctrl_byte(input logic dir, input lane_flags_t f);
        logic [LANE_W-1:0] b;
        b           = '0;
        b[DIR_BIT]  = dir;
        b[FALL_BIT] = f.fall;
        b[RISE_BIT] = f.rise;
        b[ANY_BIT]  = f.any;
        return b;
    endfunction

endpackage

// File: rtl/fio_edge_det.sv
module fio_edge_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise_ev,
    output logic [W-1:0] fall_ev
);

    logic [W-1:0] meta_q, sync_q, prev_q;

    // Two synchronizer stages, then one stage holding the previous level
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl     = sync_q;
    assign rise_ev = sync_q & ~prev_q;
    assign fall_ev = ~sync_q & prev_q;

    logic live_q;
    always_ff @(posedge clk) live_q <= !rst;

    // R5: a detected rise traces back to a high pin two clocks earlier
    a_r5_rise_origin: assert property (@(posedge clk) disable iff (rst)
        live_q |-> ((rise_ev & ~$past(pin_in, 2)) == '0));
    // R6: a detected fall traces back to a low pin two clocks earlier
    a_r6_fall_origin: assert property (@(posedge clk) disable iff (rst)
        live_q |-> ((fall_ev & $past(pin_in, 2)) == '0));

endmodule

// File: rtl/fio_w1c_stat.sv
module fio_w1c_stat #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] stat
);

    logic [W-1:0] set_v, clr_v;

    assign set_v = evt & en;
    assign clr_v = clr_wr ? clr_mask : '0;

    // A new set outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr_v) | set_v;
    end

    logic live_q;
    always_ff @(posedge clk) live_q <= !rst;

    // R7: new status bits appear only from enabled edges
    a_r7_only_enabled_sets: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (((stat & ~$past(stat)) & ~$past(evt & en)) == '0));
    // R8: bits written as 1, with no concurrent edge, are cleared
    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(clr_wr)) |-> ((stat & $past(clr_mask & ~(evt & en))) == '0));
    // R8: bits not written as 1 keep their value
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (($past(stat & ~(clr_wr ? clr_mask : '0)) & ~stat) == '0));
    // R9: an enabled edge always leaves its bit set, even during a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (($past(evt & en) & ~stat) == '0));

endmodule

// File: rtl/fio_lane_sum.sv
module fio_lane_sum
    import fio_pkg::*;
#(
    parameter int NLANE = 2,
    localparam int W = NLANE * LANE_W
) (
    input  logic [NLANE-1:0] dir,
    input  logic [W-1:0]     rise_st,
    input  logic [W-1:0]     fall_st,
    output logic [W-1:0]     ctrl_word,
    output logic [NLANE-1:0] lane_any
);

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        lane_flags_t f;
        always_comb begin
            f.rise = |rise_st[l*LANE_W +: LANE_W];
            f.fall = |fall_st[l*LANE_W +: LANE_W];
            f.any  = f.rise | f.fall;
        end
        assign ctrl_word[l*LANE_W +: LANE_W] = pack_ctrl_byte(dir[l], f);
        assign lane_any[l] = f.any;
    end

endmodule

// File: rtl/fio_edge_regs.sv
module fio_edge_regs
    import fio_pkg::*;
#(
    parameter int NLANE = 2,
    localparam int W = NLANE * LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   reg_addr,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic         irq
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    logic [NLANE-1:0] dir_q;
    logic [W-1:0]     dout_q, ren_q, fen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            dout_q <= '0;
            ren_q  <= '0;
            fen_q  <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_CTRL: begin
                    for (int l = 0; l < NLANE; l++)
                        dir_q[l] <= reg_wdata[l*LANE_W + DIR_BIT];
                end
                SEL_DOUT: dout_q <= reg_wdata;
                SEL_REN:  ren_q  <= reg_wdata;
                SEL_FEN:  fen_q  <= reg_wdata;
                default:  ;
            endcase
        end
    end

    logic [W-1:0] lvl, rise_ev, fall_ev;

    fio_edge_det #(.W(W)) u_det (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .lvl     (lvl),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    logic [W-1:0] rise_st, fall_st;

    fio_w1c_stat #(.W(W)) u_rise (
        .clk      (clk),
        .rst      (rst),
        .evt      (rise_ev),
        .en       (ren_q),
        .clr_wr   (reg_wr && sel == SEL_RSTAT),
        .clr_mask (reg_wdata),
        .stat     (rise_st)
    );

    fio_w1c_stat #(.W(W)) u_fall (
        .clk      (clk),
        .rst      (rst),
        .evt      (fall_ev),
        .en       (fen_q),
        .clr_wr   (reg_wr && sel == SEL_FSTAT),
        .clr_mask (reg_wdata),
        .stat     (fall_st)
    );

    logic [W-1:0]     ctrl_word;
    logic [NLANE-1:0] lane_any;

    fio_lane_sum #(.NLANE(NLANE)) u_sum (
        .dir       (dir_q),
        .rise_st   (rise_st),
        .fall_st   (fall_st),
        .ctrl_word (ctrl_word),
        .lane_any  (lane_any)
    );

    always_comb begin
        case (sel)
            SEL_CTRL:  reg_rdata = ctrl_word;
            SEL_DOUT:  reg_rdata = dout_q;
            SEL_DIN:   reg_rdata = lvl;
            SEL_RSTAT: reg_rdata = rise_st;
            SEL_REN:   reg_rdata = ren_q;
            SEL_FSTAT: reg_rdata = fall_st;
            SEL_FEN:   reg_rdata = fen_q;
            default:   reg_rdata = '0;
        endcase
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_oe
        assign pin_oe[l*LANE_W +: LANE_W] = {LANE_W{dir_q[l]}};
    end

    assign pin_out = dout_q;
    assign irq     = (|rise_st) | (|fall_st);

    // R2: lane 0 direction follows the written control bit
    a_r2_dir_follows: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd0) |=> (pin_oe[LANE_W-1:0] == {LANE_W{$past(reg_wdata[DIR_BIT])}}));
    // R3: the written output data reaches the pins one clock later
    a_r3_dout_drives: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd1) |=> (pin_out == $past(reg_wdata)));
    // R11: the interrupt agrees with the per-lane summary flags
    a_r11_irq_summary: assert property (@(posedge clk) disable iff (rst)
        irq == (|lane_any));

endmodule

// File: tb/sim_fio_edge_regs.sv
module sim_fio_edge_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fio_edge_regs u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset offset %0d", a), v, 16'h0000);
        end
        chk("R1 reset pin_oe", pin_oe, 16'h0000);
        chk("R1 reset pin_out", pin_out, 16'h0000);
        chk("R1 reset irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_dir;
        logic [15:0] v;
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v);
        chk("R2 ctrl reads only direction bits", v, 16'h0101);
        chk("R2 both lanes output", pin_oe, 16'hFFFF);
        wr(3'd0, 16'h0100);
        chk("R2 upper lane output only", pin_oe, 16'hFF00);
    endtask

    task automatic t_out;
        logic [15:0] v;
        wr(3'd1, 16'hA5C3);
        rd(3'd1, v);
        chk("R3 output data readback", v, 16'hA5C3);
        chk("R3 pin_out", pin_out, 16'hA5C3);
    endtask

    task automatic t_in;
        logic [15:0] v;
        pin_in = 16'h1234;
        tick(1);
        rd(3'd2, v);
        chk("R4 input not visible after one edge", v, 16'h0000);
        tick(1);
        rd(3'd2, v);
        chk("R4 input visible after two edges", v, 16'h1234);
        tick(2);
    endtask

    task automatic t_rise;
        logic [15:0] v;
        wr(3'd4, 16'h0F0F);
        pin_in = 16'hFFFF;
        tick(2);
        rd(3'd3, v);
        chk("R5 rise status not yet set", v, 16'h0000);
        tick(1);
        rd(3'd3, v);
        chk("R5 R7 rise status enabled pins only", v, 16'h0D0B);
        rd(3'd5, v);
        chk("R6 no fall status on rising pins", v, 16'h0000);
        rd(3'd0, v);
        chk("R10 ctrl rise flags both lanes", v, 16'hC1C0);
        chk("R11 irq high", {15'd0, irq}, 16'h0001);
    endtask

    task automatic t_w1c;
        logic [15:0] v;
        wr(3'd3, 16'h0003);
        rd(3'd3, v);
        chk("R8 partial clear", v, 16'h0D08);
        wr(3'd3, 16'h0000);
        rd(3'd3, v);
        chk("R8 zero write keeps bits", v, 16'h0D08);
        tick(3);
        rd(3'd3, v);
        chk("R7 status sticky", v, 16'h0D08);
        wr(3'd3, 16'h0D08);
        rd(3'd3, v);
        chk("R8 full clear", v, 16'h0000);
        chk("R11 irq low after clear", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_fall;
        logic [15:0] v;
        wr(3'd6, 16'h8001);
        pin_in = 16'h7FFE;
        tick(2);
        rd(3'd5, v);
        chk("R6 fall status not yet set", v, 16'h0000);
        tick(1);
        rd(3'd5, v);
        chk("R6 fall status", v, 16'h8001);
        rd(3'd0, v);
        chk("R10 ctrl fall flags both lanes", v, 16'hA1A0);
        pin_in = 16'hFFFF;
        tick(4);
        rd(3'd3, v);
        chk("R7 rise only where enabled", v, 16'h0001);
        rd(3'd5, v);
        chk("R7 fall status held", v, 16'h8001);
        rd(3'd0, v);
        chk("R10 ctrl mixed flags", v, 16'hA1E0);
        wr(3'd3, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        chk("R11 irq low after both cleared", {15'd0, irq}, 16'h0000);
        pin_in = 16'hFFEF;
        tick(4);
        wr(3'd6, 16'h8011);
        tick(2);
        rd(3'd5, v);
        chk("R7 late enable records no past edge", v, 16'h0000);
    endtask

    task automatic t_race;
        logic [15:0] v;
        pin_in = 16'hFFEE;
        tick(4);
        pin_in = 16'hFFEF;
        tick(4);
        rd(3'd3, v);
        chk("R5 rise on pin 0", v, 16'h0001);
        pin_in = 16'hFFEE;
        tick(4);
        // New rise on pin 0 reaches the status register in the same cycle as the clear
        pin_in = 16'hFFEF;
        tick(2);
        wr(3'd3, 16'h0001);
        rd(3'd3, v);
        chk("R9 edge wins over clear", v, 16'h0001);
        wr(3'd3, 16'h0001);
        rd(3'd3, v);
        chk("R8 clear without edge", v, 16'h0000);
        wr(3'd5, 16'hFFFF);
        chk("R11 irq low", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_misc;
        logic [15:0] v;
        wr(3'd2, 16'h0000);
        rd(3'd2, v);
        chk("R12 write to readback ignored", v, 16'hFFEF);
        wr(3'd7, 16'hFFFF);
        rd(3'd7, v);
        chk("R12 offset 7 reads zero", v, 16'h0000);
        rd(3'd1, v);
        chk("R12 output data untouched", v, 16'hA5C3);
        rd(3'd0, v);
        chk("R12 R2 control untouched", v, 16'h0100);
        rd(3'd4, v);
        chk("R12 rise enable untouched", v, 16'h0F0F);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        t_reset;
        t_dir;
        t_out;
        t_in;
        t_rise;
        t_w1c;
        t_fall;
        t_race;
        t_misc;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule